// File: doc/BRIEF.md
# Expanded-Memory Page Window Translator

This block maps CPU accesses that land inside a 64 KB expanded-memory window in upper memory onto arbitrary 16 KB frames of physical DRAM. The window is made of four consecutive 16 KB pages. Its base can be placed at one of four positions between 0xC0000 and 0xE0000, and it only claims accesses while an enable bit is set. Every page has its own frame. The frame is assembled from a coarse 5-bit field in 512 KB steps and a fine 5-bit field in 16 KB steps. Those two fields live in two separate configuration registers.

Configuration uses an index/data pair. A write with `cfg_sel` low loads the register index. A write with `cfg_sel` high stores data into the register that index names. A small state machine tracks this protocol and has two states:
- `CFG_NO_INDEX`: entered at reset.
- `CFG_INDEXED`: entered on the first index write through the transition "index loaded". It then stays there until reset.

The translator samples the CPU address and `mem_limit` on each clock. One cycle later it presents the registered hit flag, the page number, the physical address and an out-of-range flag.

Top module: `ems_window_xlate`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with `cpu_addr` at 0, `hit`, `page`, `phys_addr` and `out_of_range` are all zero. After reset the window is disabled, the base select is 0 and all page fields are 0.
- R2: A write with `cfg_sel`=0 loads `cfg_wdata` as the register index. A write with `cfg_sel`=1 stores `cfg_wdata` into the indexed register. The index persists across data writes. A data write before any index write since reset is ignored. A data write to an index other than 0x23, 0x24 to 0x2B and 0x2C is ignored.
- R3: Bit 3 of register 0x23 enables the window. While it is clear, `hit` is 0 for every address. All other bits of 0x23 are ignored.
- R4: Bits [1:0] of register 0x2C place the window base: 0 gives 0xC0000, 1 gives 0xC8000, 2 gives 0xD0000 and 3 gives 0xE0000. All other bits of 0x2C are ignored.
- R5: `hit` is 1 exactly when the window is enabled and base <= address < base+0x10000. The addresses base-1 and base+0x10000 miss.
- R6: On a hit, `page` equals bits [15:14] of (address - base).
- R7: Page n (0..3) uses register 0x24+2n as its coarse field and 0x25+2n as its fine field. Its frame is coarse[4:0]<<19 | fine[4:0]<<14. Bits [7:5] of both registers are ignored.
- R8: On a hit, `phys_addr` is the page's frame plus address bits [13:0].
- R9: On a miss, `phys_addr` equals the CPU address and `page` is 0.
- R10: `out_of_range` is 1 exactly when there is a hit and `phys_addr` >= the `mem_limit` sampled on the same edge.
- R11: The outputs are registered. They reflect the address presented before the previous rising edge and do not change between edges. A configuration write takes effect for the address sampled on the next edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = index write, 1 = data write |
| cfg_wdata | input | 8 | Configuration write value |
| cpu_addr | input | 24 | CPU address to translate |
| mem_limit | input | 24 | Installed memory size in bytes |
| hit | output | 1 | Address falls inside the enabled window |
| page | output | 2 | Window page that was hit |
| phys_addr | output | 24 | Translated (or passed-through) address |
| out_of_range | output | 1 | Translated address at or above `mem_limit` |

## Verification
Two cases are hard to reach from the ports.

The first is a data write before any index write. It can only be made right after reset. The stimulus therefore issues a data write that carries the enable bit first. It then probes the window to show that nothing was enabled.

The second is the 0xC8000 placement. Here the window straddles a 64 KB boundary, so the page number cannot be read straight from address bits. The stimulus moves the base through all four positions and probes the first and last bytes and both neighbours. Page registers are written with junk in their upper bits, and frames are chosen so that one page lands exactly on `mem_limit`.

// File: rtl/ems_pkg.sv
package ems_pkg;
    localparam int ADDR_W = 24;
    localparam int OFS_W  = 14;
    localparam int PAGES  = 4;
    localparam int PG_W   = $clog2(PAGES);
    localparam int FLD_W  = 5;
    localparam int FINE_SHIFT   = OFS_W;
    localparam int COARSE_SHIFT = OFS_W + FLD_W;

    localparam logic [7:0] IDX_CTRL  = 8'h23;
    localparam logic [7:0] IDX_PAGE0 = 8'h24;
    localparam logic [7:0] IDX_BASE  = 8'h2C;
    localparam int         EN_BIT    = 3;

    typedef enum logic [0:0] {
        CFG_NO_INDEX = 1'b0,
        CFG_INDEXED  = 1'b1
    } cfg_state_t;

    function automatic logic [ADDR_W-1:0] window_base(input logic [1:0] sel);
        logic [ADDR_W-1:0] b;
        unique case (sel)
            2'd0: b = ADDR_W'(24'h0C0000);
            2'd1: b = ADDR_W'(24'h0C8000);
            2'd2: b = ADDR_W'(24'h0D0000);
            default: b = ADDR_W'(24'h0E0000);
        endcase
        return b;
    endfunction
endpackage

// File: rtl/ems_cfg_port.sv
module ems_cfg_port
    import ems_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic                          sel,
    input  logic [7:0]                    wdata,
    output cfg_state_t                    state,
    output logic                          win_en,
    output logic [1:0]                    base_sel,
    output logic [PAGES-1:0][FLD_W-1:0]   coarse,
    output logic [PAGES-1:0][FLD_W-1:0]   fine
);
    cfg_state_t state_nx;
    logic [7:0] idx_q;
    logic       commit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CFG_NO_INDEX;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            CFG_NO_INDEX: if (we && !sel) state_nx = CFG_INDEXED;
            CFG_INDEXED:  state_nx = CFG_INDEXED;
        endcase
    end

    // outputs of the protocol: commit strobe
    always_comb begin
        commit = 1'b0;
        unique case (state)
            CFG_NO_INDEX: commit = 1'b0;
            CFG_INDEXED:  commit = we && sel;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             idx_q <= '0;
        else if (we && !sel)    idx_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_en   <= 1'b0;
            base_sel <= 2'd0;
        end else if (commit) begin
            if (idx_q == IDX_CTRL) win_en   <= wdata[EN_BIT];
            if (idx_q == IDX_BASE) base_sel <= wdata[1:0];
        end
    end

    for (genvar p = 0; p < PAGES; p++) begin : g_slot
        localparam logic [7:0] IDX_C = IDX_PAGE0 + 8'(2 * p);
        localparam logic [7:0] IDX_F = IDX_PAGE0 + 8'(2 * p + 1);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                coarse[p] <= '0;
                fine[p]   <= '0;
            end else if (commit) begin
                if (idx_q == IDX_C) coarse[p] <= wdata[FLD_W-1:0];
                if (idx_q == IDX_F) fine[p]   <= wdata[FLD_W-1:0];
            end
        end
    end
endmodule

// File: rtl/ems_frame_table.sv
module ems_frame_table
    import ems_pkg::*;
(
    input  logic [PAGES-1:0][FLD_W-1:0] coarse,
    input  logic [PAGES-1:0][FLD_W-1:0] fine,
    input  logic [PG_W-1:0]             pg,
    output logic [ADDR_W-1:0]           frame
);
    logic [PAGES-1:0][ADDR_W-1:0] frames;

    for (genvar p = 0; p < PAGES; p++) begin : g_frame
        assign frames[p] = (ADDR_W'(coarse[p]) << COARSE_SHIFT)
                         | (ADDR_W'(fine[p])   << FINE_SHIFT);
    end

    assign frame = frames[pg];
endmodule

// File: rtl/ems_window_decode.sv
module ems_window_decode
    import ems_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic [1:0]        base_sel,
    output logic              in_win,
    output logic [PG_W-1:0]   pg,
    output logic [OFS_W-1:0]  ofs
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(PAGES) << OFS_W;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] diff;

    always_comb begin
        base   = window_base(base_sel);
        diff   = addr - base;
        in_win = en && (addr >= base) && (diff < SPAN);
        pg     = diff[OFS_W +: PG_W];
        ofs    = diff[OFS_W-1:0];
    end
endmodule

// File: rtl/ems_window_xlate.sv
module ems_window_xlate
    import ems_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [7:0]        cfg_wdata,
    input  logic [23:0]       cpu_addr,
    input  logic [23:0]       mem_limit,
    output logic              hit,
    output logic [1:0]        page,
    output logic [23:0]       phys_addr,
    output logic              out_of_range
);
    cfg_state_t                  cfg_state;
    logic                        win_en;
    logic [1:0]                  base_sel;
    logic [PAGES-1:0][FLD_W-1:0] coarse;
    logic [PAGES-1:0][FLD_W-1:0] fine;
    logic                        in_win;
    logic [PG_W-1:0]             pg;
    logic [OFS_W-1:0]            ofs;
    logic [ADDR_W-1:0]           frame;
    logic [ADDR_W-1:0]           phys_nx;
    logic                        oor_nx;
    logic [PG_W-1:0]             page_nx;

    ems_cfg_port u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .state(cfg_state), .win_en(win_en), .base_sel(base_sel),
        .coarse(coarse), .fine(fine)
    );

    ems_window_decode u_dec (
        .addr(cpu_addr), .en(win_en), .base_sel(base_sel),
        .in_win(in_win), .pg(pg), .ofs(ofs)
    );

    ems_frame_table u_tab (
        .coarse(coarse), .fine(fine), .pg(pg), .frame(frame)
    );

    always_comb begin
        phys_nx = in_win ? (frame + ADDR_W'(ofs)) : cpu_addr;
        page_nx = in_win ? pg : '0;
        oor_nx  = in_win && (phys_nx >= mem_limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit          <= 1'b0;
            page         <= '0;
            phys_addr    <= '0;
            out_of_range <= 1'b0;
        end else begin
            hit          <= in_win;
            page         <= page_nx;
            phys_addr    <= phys_nx;
            out_of_range <= oor_nx;
        end
    end
endmodule

// File: rtl/ems_window_checker.sv
module ems_window_checker
    import ems_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic        cfg_sel,
    input cfg_state_t  cfg_state,
    input logic        win_en,
    input logic [23:0] cpu_addr,
    input logic [23:0] mem_limit,
    input logic        hit,
    input logic [1:0]  page,
    input logic [23:0] phys_addr,
    input logic        out_of_range
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r3_disabled_miss: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(win_en) |-> !hit);

    a_r9_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !hit |-> (phys_addr == $past(cpu_addr)) && (page == 2'd0));

    a_r8_offset_kept: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        hit |-> phys_addr[13:0] == $past(cpu_addr[13:0]));

    a_r5_hit_in_upper_mem: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        hit |-> ($past(cpu_addr[23:20]) == 4'd0) && ($past(cpu_addr[19:18]) == 2'b11));

    a_r10_oor_needs_hit: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        out_of_range |-> hit && (phys_addr >= $past(mem_limit)));

    a_r2_no_index_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_state == CFG_NO_INDEX && cfg_we && cfg_sel) |=> $stable(win_en));
endmodule

bind ems_window_xlate ems_window_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_state(cfg_state), .win_en(win_en), .cpu_addr(cpu_addr),
    .mem_limit(mem_limit), .hit(hit), .page(page), .phys_addr(phys_addr),
    .out_of_range(out_of_range)
);

// File: tb/sim_ems_window_xlate.sv
module sim_ems_window_xlate;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [23:0] cpu_addr = '0;
    logic [23:0] mem_limit = 24'hFFFFFF;
    logic        hit, out_of_range;
    logic [1:0]  page;
    logic [23:0] phys_addr;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model of the configuration state
    bit       m_has_idx = 0;
    bit [7:0] m_idx = 0;
    bit       m_en = 0;
    bit [1:0] m_sel = 0;
    bit [4:0] m_coarse [4];
    bit [4:0] m_fine   [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    ems_window_xlate u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cpu_addr(cpu_addr), .mem_limit(mem_limit),
        .hit(hit), .page(page), .phys_addr(phys_addr), .out_of_range(out_of_range)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // caller is at a negedge; returns at a negedge
    task automatic cfg_write(input bit sel, input bit [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        if (!sel) begin
            m_idx = d; m_has_idx = 1;
        end else if (m_has_idx) begin
            if (m_idx == 8'h23) m_en = d[3];
            else if (m_idx == 8'h2C) m_sel = d[1:0];
            else if (m_idx >= 8'h24 && m_idx <= 8'h2B) begin
                if (m_idx[0] == 1'b0) m_coarse[(m_idx - 8'h24) >> 1] = d[4:0];
                else                  m_fine[(m_idx - 8'h24) >> 1]   = d[4:0];
            end
        end
    endtask

    task automatic reg_write(input bit [7:0] idx, input bit [7:0] d);
        cfg_write(0, idx);
        cfg_write(1, d);
    endtask

    function automatic bit [23:0] base_of(input bit [1:0] s);
        case (s)
            2'd0: return 24'h0C0000;
            2'd1: return 24'h0C8000;
            2'd2: return 24'h0D0000;
            default: return 24'h0E0000;
        endcase
    endfunction

    // present an address, compare the registered result one edge later
    task automatic probe(input string req, input bit [23:0] a);
        bit [23:0] b, diff, ph;
        bit        h, o;
        bit [1:0]  pg;
        cpu_addr = a;
        b    = base_of(m_sel);
        diff = a - b;
        h    = m_en && (a >= b) && (diff < 24'h10000);
        pg   = h ? diff[15:14] : 2'd0;
        ph   = h ? (({19'd0, m_coarse[pg]} << 19) | ({19'd0, m_fine[pg]} << 14)) + {10'd0, diff[13:0]} : a;
        o    = h && (ph >= mem_limit);
        @(posedge clk);
        @(negedge clk);
        check(req, $sformatf("hit @%h", a), 32'(hit), 32'(h));
        check(req, $sformatf("page @%h", a), 32'(page), 32'(pg));
        check(req, $sformatf("phys @%h", a), 32'(phys_addr), 32'(ph));
        check(req, $sformatf("oor @%h", a), 32'(out_of_range), 32'(o));
    endtask

    task automatic t_reset;
        check("R1", "hit in reset", 32'(hit), 0);
        check("R1", "phys in reset", 32'(phys_addr), 0);
        check("R1", "oor in reset", 32'(out_of_range), 0);
        @(negedge clk); rst_n = 1'b1;
        probe("R1", 24'h000000);
    endtask

    task automatic t_early_data;
        cfg_write(1, 8'hFF);           // R2: no index yet, ignored
        probe("R2", 24'h0C0000);
    endtask

    task automatic t_disabled;
        reg_write(8'h23, 8'hF7);       // R3: enable bit clear, others set
        reg_write(8'h2C, 8'h00);
        probe("R3", 24'h0C0000);
        probe("R3", 24'h0CFFFF);
    endtask

    task automatic t_frames;
        reg_write(8'h24, 8'hE3); reg_write(8'h25, 8'hFF);
        reg_write(8'h26, 8'h00); reg_write(8'h27, 8'h01);
        reg_write(8'h28, 8'h1F); reg_write(8'h29, 8'h00);
        reg_write(8'h2A, 8'h0A); reg_write(8'h2B, 8'h15);
        reg_write(8'h23, 8'h08);
        for (int p = 0; p < 4; p++) begin
            probe("R7", 24'h0C0000 + 24'(p) * 24'h4000);
            probe("R8", 24'h0C0000 + 24'(p) * 24'h4000 + 24'h2A5B);
        end
    endtask

    task automatic t_bases;
        for (int s = 0; s < 4; s++) begin
            bit [23:0] b;
            reg_write(8'h2C, 8'hFC | 8'(s)); // R4: upper bits ignored
            b = base_of(2'(s));
            probe("R4", b);
            probe("R5", b + 24'h0FFFF);
            probe("R5", b - 24'h1);
            probe("R5", b + 24'h10000);
            probe("R6", b + 24'h0BFFF);
            probe("R9", 24'h123456);
        end
    endtask

    task automatic t_persist_and_unlisted;
        cfg_write(0, 8'h2C);
        cfg_write(1, 8'h02);
        cfg_write(1, 8'h01);           // R2: index persists
        probe("R2", 24'h0C8000);
        reg_write(8'h2D, 8'h03);       // R2: unlisted index ignored
        reg_write(8'h22, 8'h00);
        probe("R2", 24'h0C8000);
        probe("R2", 24'h0E0000);
    endtask

    task automatic t_oor;
        reg_write(8'h2C, 8'h00);
        mem_limit = 24'h1FC000;        // page 0 frame sits exactly on the limit
        probe("R10", 24'h0C0000);
        probe("R10", 24'h0C4000);      // page 1 frame 0x4000 below limit
        mem_limit = 24'h1FC001;
        probe("R10", 24'h0C0000);
        probe("R10", 24'h0C0001);
        probe("R10", 24'h0B0000);      // miss never out of range
        mem_limit = 24'hFFFFFF;
    endtask

    task automatic t_latency;
        probe("R11", 24'h0C0010);
        cpu_addr = 24'h050000;
        #1;
        check("R11", "hit held before edge", 32'(hit), 1);
        @(posedge clk); @(negedge clk);
        check("R11", "miss one edge later", 32'(hit), 0);
        // config change visible for the address sampled on the next edge
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'h23;
        @(posedge clk); @(negedge clk);
        cfg_sel = 1'b1; cfg_wdata = 8'h00; cpu_addr = 24'h0C0000;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        check("R11", "hit sampled at write edge", 32'(hit), 1);
        m_idx = 8'h23; m_en = 0;
        probe("R11", 24'h0C0000);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin m_coarse[i] = 0; m_fine[i] = 0; end
        @(negedge clk);
        t_reset;
        t_early_data;
        t_disabled;
        t_frames;
        t_bases;
        t_persist_and_unlisted;
        t_oor;
        t_latency;
        finish_run;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run;
    end
endmodule